// File: doc/BRIEF.md
# System Bus Address Decoder with Boot ROM Overlay

This block decodes every access on a 24-bit, 68000-style system bus into a single target. It drives chip selects and masked offsets toward external ROM, main RAM, the 2 KB map RAM, the 32 KB video RAM and eight expansion slots. It also answers reads of three 16-bit status registers itself, formatting the 16-bit value for byte, word or long transfers. The memories and peripheral controllers sit outside the block. Bus handshake timing and access-permission checks belong to other logic.

After reset a boot overlay is active: address bit 23 is forced high before decoding, so every fetch lands in ROM. Software ends the overlay by writing a one to the overlay control location in the upper I/O zone. An access that no region claims returns all ones on a read. A one-cycle unhandled pulse marks it, and a capture register keeps the effective address, direction, size and write data of the most recent such access.

Size encoding on `size_i` and `cap_size_o`: 2'b00 byte, 2'b01 word, 2'b10 long (2'b11 is treated as long). The effective address is the incoming address after overlay forcing.

Top module: `bus_addr_decoder`

## Requirements
- R1: While rst_ni is low and after release, map_en_o is 0, unhandled_o is 0, and the capture outputs are all zero.
- R2: While map_en_o is 0, bit 23 of addr_i is forced to 1 before decoding. A read of 0x000010 therefore selects ROM at offset 0x000010, and RAM, map RAM and video RAM are never selected.
- R3: Effective addresses 0x800000–0xBFFFFF assert cs_rom_o with offset_o equal to the address minus 0x800000. ROM writes are handled and produce no unhandled pulse.
- R4: Effective addresses below parameter RAM_BYTES assert cs_ram_o with offset_o equal to the address. Where the two ranges overlap, ROM wins over RAM.
- R5: Effective addresses 0x400000–0x7FFFFF are decoded on bits 19:16: 0 map RAM, 1 general status, 2 video RAM, 3 bus status 0, 4 bus status 1. Values 5–15 are unhandled.
- R6: The map RAM offset is the address masked to 0x7FF, and the video RAM offset is the address masked to 0x7FFF. mirror_o is 1 when the address exceeds 0x4007FF (map RAM) or 0x427FFF (video RAM).
- R7: A status read sets rdata_own_o. A long read returns the 16-bit value in both halves, a word read returns it zero-extended, and a byte read returns bits 15:8 at an even address and bits 7:0 at an odd address.
- R8: Writes to any status register are accepted, change nothing and produce no unhandled pulse.
- R9: A write to an effective address with bits 23:21 = 3'b111 and bits 18:12 = 0x43 controls the overlay. A word or long write loads map_en_o from wdata_i[15]. An even byte write loads it from wdata_i[7]. An odd byte write is handled but leaves it unchanged.
- R10: A read that no region claims sets rdata_own_o and returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or long. A read of the overlay control location is unclaimed.
- R11: Effective addresses 0xC00000–0xDFFFFF assert exactly bit (address−0xC00000)/0x40000 of cs_slot_o, with offset_o equal to the address masked to 0x3FFFF.
- R12: One cycle after an unclaimed access, unhandled_o is 1 for one cycle. At the same time cap_addr_o, cap_we_o, cap_size_o and cap_data_o (write data, or 0 for reads) take the access. Claimed accesses leave unhandled_o at 0.
- R13: During any access, at most one of cs_rom_o, cs_ram_o, cs_map_o, cs_vram_o and cs_slot_o is active, and none is active when the access is unclaimed.
- R14: With req_i low, every select, mirror_o and rdata_own_o are 0, and no unhandled pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 write, 0 read |
| size_i | input | 2 | Transfer size (00 byte, 01 word, 10 long) |
| addr_i | input | 24 | Bus address |
| wdata_i | input | 32 | Write data (byte in bits 7:0, word in bits 15:0) |
| gen_stat_i | input | 16 | General status register value |
| bus_stat0_i | input | 16 | Bus status register 0 value |
| bus_stat1_i | input | 16 | Bus status register 1 value |
| cs_rom_o | output | 1 | ROM select |
| cs_ram_o | output | 1 | Main RAM select |
| cs_map_o | output | 1 | Map RAM select |
| cs_vram_o | output | 1 | Video RAM select |
| cs_slot_o | output | 8 | One-hot expansion slot select |
| offset_o | output | 24 | Masked offset for the selected memory |
| mirror_o | output | 1 | Map or video RAM accessed through a mirror |
| rdata_o | output | 32 | Read data sourced by the block |
| rdata_own_o | output | 1 | rdata_o is valid for this read |
| map_en_o | output | 1 | Overlay finished (normal map active) |
| unhandled_o | output | 1 | Pulse one cycle after an unclaimed access |
| cap_addr_o | output | 24 | Effective address of last unclaimed access |
| cap_we_o | output | 1 | Direction of last unclaimed access |
| cap_size_o | output | 2 | Size of last unclaimed access |
| cap_data_o | output | 32 | Write data of last unclaimed access, 0 for reads |

## Verification
Several properties are checked on every clock cycle. There is never more than one memory select. RAM, map RAM and video RAM are never selected while the overlay is active. mirror_o only appears together with a map or video RAM select. Idle cycles stay quiet. The unhandled pulse tracks unclaimed accesses, the capture register holds its value when nothing is missed, and an odd byte write never changes the overlay flag. The other behaviours need the bench's sweeps to show them: the exact address boundaries, the masked offsets, the byte-lane choice, the all-ones fill per width, the slot numbering, the RAM-over-zone priority in a large-RAM configuration, and the sequence of overlay writes.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned SLOT_IW = 3;
  localparam int unsigned SLOT_CNT = 1 << SLOT_IW;
  localparam int unsigned SLOT_SPAN_W = 21 - SLOT_IW;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

  localparam logic [6:0] CTRL_SEL = 7'h43;

  typedef enum logic [3:0] {
    RG_NONE, RG_ROM, RG_RAM, RG_MAP, RG_VRAM,
    RG_GSTAT, RG_BSTAT0, RG_BSTAT1, RG_SLOT, RG_CTRL
  } region_e;
endpackage

// File: rtl/busdec_region.sv
module busdec_region
  import busdec_pkg::*;
#(
  parameter int unsigned RAM_BYTES  = 32'h0008_0000,
  parameter int unsigned MAP_BYTES  = 2048,
  parameter int unsigned VRAM_BYTES = 32768
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  output region_e            region_o,
  output logic [SLOT_IW-1:0] slot_o,
  output logic [ADDR_W-1:0]  offset_o,
  output logic               mirror_o
);
  localparam logic [ADDR_W-1:0] ZA_BASE   = 24'h40_0000;
  localparam logic [ADDR_W-1:0] VRAM_BASE = 24'h42_0000;
  localparam logic [ADDR_W-1:0] MAP_MASK  = ADDR_W'(MAP_BYTES - 1);
  localparam logic [ADDR_W-1:0] VRAM_MASK = ADDR_W'(VRAM_BYTES - 1);
  localparam logic [ADDR_W-1:0] SLOT_MASK = ADDR_W'((1 << SLOT_SPAN_W) - 1);
  localparam logic [ADDR_W-1:0] MAP_TOP   = ZA_BASE | MAP_MASK;
  localparam logic [ADDR_W-1:0] VRAM_TOP  = VRAM_BASE | VRAM_MASK;

  assign slot_o = addr_i[SLOT_SPAN_W +: SLOT_IW];

  always_comb begin
    region_o = RG_NONE;
    offset_o = '0;
    mirror_o = 1'b0;
    if (addr_i[23:22] == 2'b10) begin
      region_o = RG_ROM;
      offset_o = {2'b00, addr_i[21:0]};
    end else if (32'(addr_i) < RAM_BYTES) begin
      region_o = RG_RAM;
      offset_o = addr_i;
    end else if (addr_i[23:22] == 2'b01) begin
      case (addr_i[19:16])
        4'h0: begin
          region_o = RG_MAP;
          offset_o = addr_i & MAP_MASK;
          mirror_o = addr_i > MAP_TOP;
        end
        4'h1: region_o = RG_GSTAT;
        4'h2: begin
          region_o = RG_VRAM;
          offset_o = addr_i & VRAM_MASK;
          mirror_o = addr_i > VRAM_TOP;
        end
        4'h3: region_o = RG_BSTAT0;
        4'h4: region_o = RG_BSTAT1;
        default: region_o = RG_NONE;
      endcase
    end else if (addr_i[23:21] == 3'b110) begin
      region_o = RG_SLOT;
      offset_o = addr_i & SLOT_MASK;
    end else if (addr_i[23:21] == 3'b111 && addr_i[18:12] == CTRL_SEL && we_i) begin
      region_o = RG_CTRL;
    end
  end
endmodule

// File: rtl/busdec_rdfmt.sv
module busdec_rdfmt
  import busdec_pkg::*;
(
  input  region_e           region_i,
  input  logic [1:0]        size_i,
  input  logic              odd_i,
  input  logic [REG_W-1:0]  gstat_i,
  input  logic [REG_W-1:0]  bstat0_i,
  input  logic [REG_W-1:0]  bstat1_i,
  output logic [DATA_W-1:0] data_o,
  output logic              st_hit_o
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel      = '0;
    st_hit_o = 1'b1;
    case (region_i)
      RG_GSTAT:  sel = gstat_i;
      RG_BSTAT0: sel = bstat0_i;
      RG_BSTAT1: sel = bstat1_i;
      default:   st_hit_o = 1'b0;
    endcase
  end

  always_comb begin
    if (st_hit_o) begin
      if (size_i == SZ_BYTE)      data_o = {24'h0, odd_i ? sel[7:0] : sel[15:8]};
      else if (size_i == SZ_WORD) data_o = {16'h0, sel};
      else                        data_o = {sel, sel};
    end else begin
      // unclaimed read: all ones for the transfer width
      if (size_i == SZ_BYTE)      data_o = 32'h0000_00FF;
      else if (size_i == SZ_WORD) data_o = 32'h0000_FFFF;
      else                        data_o = 32'hFFFF_FFFF;
    end
  end
endmodule

// File: rtl/busdec_overlay.sv
module busdec_overlay
  import busdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] size_i,
  input  logic       odd_i,
  input  logic       bit15_i,
  input  logic       bit7_i,
  output logic       flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (wr_i) begin
      if (size_i != SZ_BYTE) flag_o <= bit15_i;
      else if (!odd_i)       flag_o <= bit7_i;
    end
  end

  assert_odd_byte_keeps_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == SZ_BYTE && odd_i) |=> $stable(flag_o));
endmodule

// File: rtl/busdec_capture.sv
module busdec_capture
  import busdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pulse_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic              cap_we_o,
  output logic [1:0]        cap_size_o,
  output logic [DATA_W-1:0] cap_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o    <= 1'b0;
      cap_addr_o <= '0;
      cap_we_o   <= 1'b0;
      cap_size_o <= '0;
      cap_data_o <= '0;
    end else begin
      pulse_o <= miss_i;
      if (miss_i) begin
        cap_addr_o <= addr_i;
        cap_we_o   <= we_i;
        cap_size_o <= size_i;
        cap_data_o <= we_i ? wdata_i : '0;
      end
    end
  end

  assert_pulse_after_miss_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> pulse_o);
  assert_no_pulse_on_hit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> !pulse_o);
  assert_capture_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> ($stable(cap_addr_o) && $stable(cap_data_o) && $stable(cap_we_o)));
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import busdec_pkg::*;
#(
  parameter int unsigned RAM_BYTES  = 32'h0008_0000,
  parameter int unsigned MAP_BYTES  = 2048,
  parameter int unsigned VRAM_BYTES = 32768
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          size_i,
  input  logic [23:0]         addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [15:0]         gen_stat_i,
  input  logic [15:0]         bus_stat0_i,
  input  logic [15:0]         bus_stat1_i,
  output logic                cs_rom_o,
  output logic                cs_ram_o,
  output logic                cs_map_o,
  output logic                cs_vram_o,
  output logic [7:0]          cs_slot_o,
  output logic [23:0]         offset_o,
  output logic                mirror_o,
  output logic [31:0]         rdata_o,
  output logic                rdata_own_o,
  output logic                map_en_o,
  output logic                unhandled_o,
  output logic [23:0]         cap_addr_o,
  output logic                cap_we_o,
  output logic [1:0]          cap_size_o,
  output logic [31:0]         cap_data_o
);
  localparam logic [ADDR_W-1:0] FORCE_ROM = 24'h80_0000;

  logic [ADDR_W-1:0]  eff_addr;
  region_e            region;
  logic [SLOT_IW-1:0] slot_idx;
  logic [ADDR_W-1:0]  dec_offset;
  logic               dec_mirror;
  logic [DATA_W-1:0]  fmt_data;
  logic               st_hit;
  logic               miss;
  logic               ctrl_wr;

  assign eff_addr = map_en_o ? addr_i : (addr_i | FORCE_ROM);

  busdec_region #(
    .RAM_BYTES (RAM_BYTES),
    .MAP_BYTES (MAP_BYTES),
    .VRAM_BYTES(VRAM_BYTES)
  ) u_region (
    .addr_i  (eff_addr),
    .we_i    (we_i),
    .region_o(region),
    .slot_o  (slot_idx),
    .offset_o(dec_offset),
    .mirror_o(dec_mirror)
  );

  busdec_rdfmt u_rdfmt (
    .region_i(region),
    .size_i  (size_i),
    .odd_i   (addr_i[0]),
    .gstat_i (gen_stat_i),
    .bstat0_i(bus_stat0_i),
    .bstat1_i(bus_stat1_i),
    .data_o  (fmt_data),
    .st_hit_o(st_hit)
  );

  assign miss    = req_i && (region == RG_NONE);
  assign ctrl_wr = req_i && (region == RG_CTRL);

  busdec_overlay u_overlay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .size_i (size_i),
    .odd_i  (addr_i[0]),
    .bit15_i(wdata_i[15]),
    .bit7_i (wdata_i[7]),
    .flag_o (map_en_o)
  );

  busdec_capture u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .miss_i    (miss),
    .addr_i    (eff_addr),
    .we_i      (we_i),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .pulse_o   (unhandled_o),
    .cap_addr_o(cap_addr_o),
    .cap_we_o  (cap_we_o),
    .cap_size_o(cap_size_o),
    .cap_data_o(cap_data_o)
  );

  assign cs_rom_o  = req_i && (region == RG_ROM);
  assign cs_ram_o  = req_i && (region == RG_RAM);
  assign cs_map_o  = req_i && (region == RG_MAP);
  assign cs_vram_o = req_i && (region == RG_VRAM);

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    assign cs_slot_o[g] = req_i && (region == RG_SLOT) && (slot_idx == SLOT_IW'(g));
  end

  assign offset_o    = req_i ? dec_offset : '0;
  assign mirror_o    = req_i && dec_mirror;
  assign rdata_own_o = req_i && !we_i && (st_hit || region == RG_NONE);
  assign rdata_o     = rdata_own_o ? fmt_data : '0;

  assert_one_target_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ($countones({cs_rom_o, cs_ram_o, cs_map_o, cs_vram_o, cs_slot_o, unhandled_o & 1'b0, miss}) <= 1));
  assert_overlay_forces_rom_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_o |-> !(cs_ram_o || cs_map_o || cs_vram_o));
  assert_mirror_in_memory_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_o |-> (cs_map_o || cs_vram_o));
  assert_idle_quiet_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> ({cs_rom_o, cs_ram_o, cs_map_o, cs_vram_o, cs_slot_o, mirror_o, rdata_own_o} == '0));
  assert_idle_no_pulse_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !unhandled_o);
endmodule

// File: tb/bus_addr_decoder_bench.sv
module bus_addr_decoder_bench;
  localparam int unsigned RAM_B = 32'h0008_0000;
  localparam int unsigned BIG_B = 32'h00C0_0000;
  localparam logic [15:0] GST = 16'hA55A;
  localparam logic [15:0] BS0 = 16'h1234;
  localparam logic [15:0] BS1 = 16'hC3E1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req, we;
  logic [1:0] sz;
  logic [23:0] addr;
  logic [31:0] wdata;

  logic cs_rom, cs_ram, cs_map, cs_vram, mirror, own, map_en, unh, cap_we;
  logic [7:0] cs_slot;
  logic [23:0] offset, cap_addr;
  logic [31:0] rdata, cap_data;
  logic [1:0] cap_size;

  logic b_rom, b_ram, b_map, b_vram, b_mir, b_own, b_men, b_unh, b_cwe;
  logic [7:0] b_slot;
  logic [23:0] b_off, b_caddr;
  logic [31:0] b_rd, b_cdata;
  logic [1:0] b_csize;

  bus_addr_decoder #(.RAM_BYTES(RAM_B)) u_bus_addr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz), .addr_i(addr),
    .wdata_i(wdata), .gen_stat_i(GST), .bus_stat0_i(BS0), .bus_stat1_i(BS1),
    .cs_rom_o(cs_rom), .cs_ram_o(cs_ram), .cs_map_o(cs_map), .cs_vram_o(cs_vram),
    .cs_slot_o(cs_slot), .offset_o(offset), .mirror_o(mirror), .rdata_o(rdata),
    .rdata_own_o(own), .map_en_o(map_en), .unhandled_o(unh), .cap_addr_o(cap_addr),
    .cap_we_o(cap_we), .cap_size_o(cap_size), .cap_data_o(cap_data));

  bus_addr_decoder #(.RAM_BYTES(BIG_B)) u_bus_addr_decoder_big (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz), .addr_i(addr),
    .wdata_i(wdata), .gen_stat_i(GST), .bus_stat0_i(BS0), .bus_stat1_i(BS1),
    .cs_rom_o(b_rom), .cs_ram_o(b_ram), .cs_map_o(b_map), .cs_vram_o(b_vram),
    .cs_slot_o(b_slot), .offset_o(b_off), .mirror_o(b_mir), .rdata_o(b_rd),
    .rdata_own_o(b_own), .map_en_o(b_men), .unhandled_o(b_unh), .cap_addr_o(b_caddr),
    .cap_we_o(b_cwe), .cap_size_o(b_csize), .cap_data_o(b_cdata));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic flag_m = 1'b0;

  logic x_rom, x_ram, x_map, x_vram, x_mir, x_own, x_miss, x_ctrl;
  logic [7:0] x_slot;
  logic [23:0] x_off, x_eff;
  logic [31:0] x_rd;
  string x_tag;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (addr %h)", tag, what, act, exp, addr);
    end
  endtask

  task automatic model(input logic [23:0] a, input logic w, input logic [1:0] s);
    int unsigned e, sub;
    logic [15:0] v;
    logic is_st;
    e = flag_m ? 32'(a) : 32'(a | 24'h800000);
    x_eff = 24'(e);
    {x_rom, x_ram, x_map, x_vram, x_mir, x_own, x_miss, x_ctrl} = '0;
    x_slot = '0; x_off = '0; x_rd = '0; v = '0; is_st = 1'b0;
    if (e >= 32'h800000 && e <= 32'hBFFFFF) begin
      x_rom = 1'b1; x_off = 24'(e - 32'h800000); x_tag = flag_m ? "R3" : "R2";
    end else if (e < RAM_B) begin
      x_ram = 1'b1; x_off = 24'(e); x_tag = "R4";
    end else if (e >= 32'h400000 && e <= 32'h7FFFFF) begin
      sub = (e / 32'h10000) % 16;
      if (sub == 0) begin
        x_map = 1'b1; x_off = 24'(e % 2048); x_mir = e > 32'h4007FF; x_tag = "R6";
      end else if (sub == 2) begin
        x_vram = 1'b1; x_off = 24'(e % 32768); x_mir = e > 32'h427FFF; x_tag = "R6";
      end else if (sub == 1 || sub == 3 || sub == 4) begin
        is_st = 1'b1;
        v = (sub == 1) ? GST : (sub == 3) ? BS0 : BS1;
        x_tag = w ? "R8" : "R7";
      end else begin
        x_miss = 1'b1; x_tag = "R5";
      end
    end else if (e >= 32'hC00000 && e <= 32'hDFFFFF) begin
      x_slot = 8'(1 << ((e - 32'hC00000) / 32'h40000));
      x_off = 24'(e % 32'h40000); x_tag = "R11";
    end else if (e >= 32'hE00000 && ((e / 32'h1000) % 128) == 32'h43 && w) begin
      x_ctrl = 1'b1; x_tag = "R9";
    end else begin
      x_miss = 1'b1; x_tag = w ? "R12" : "R10";
    end
    if (!w && (is_st || x_miss)) begin
      x_own = 1'b1;
      if (is_st) begin
        if (s == 2'b00)      x_rd = {24'h0, a[0] ? v[7:0] : v[15:8]};
        else if (s == 2'b01) x_rd = {16'h0, v};
        else                 x_rd = {v, v};
      end else begin
        if (s == 2'b00)      x_rd = 32'hFF;
        else if (s == 2'b01) x_rd = 32'hFFFF;
        else                 x_rd = 32'hFFFF_FFFF;
      end
    end
  endtask

  task automatic access(input logic [23:0] a, input logic w, input logic [1:0] s, input logic [31:0] d);
    model(a, w, s);
    @(negedge clk);
    req = 1'b1; we = w; sz = s; addr = a; wdata = d;
    #1;
    check(x_tag, "selects", 32'({cs_rom, cs_ram, cs_map, cs_vram, cs_slot}),
          32'({x_rom, x_ram, x_map, x_vram, x_slot}));
    check("R13", "select count", 32'($countones({cs_rom, cs_ram, cs_map, cs_vram, cs_slot})),
          32'((x_miss || x_ctrl || x_own || (w && !(x_rom||x_ram||x_map||x_vram||x_slot!=0))) ? 0 : 1));
    check(x_tag, "offset", 32'(offset), 32'(x_off));
    check(x_tag, "mirror", 32'(mirror), 32'(x_mir));
    check(x_tag, "rdata_own", 32'(own), 32'(x_own));
    if (x_own) check(x_tag, "rdata", rdata, x_rd);
    @(negedge clk);
    req = 1'b0;
    #1;
    check(x_miss ? "R12" : x_tag, "unhandled", 32'(unh), 32'(x_miss));
    if (x_miss) begin
      check("R12", "cap_addr", 32'(cap_addr), 32'(x_eff));
      check("R12", "cap_we", 32'(cap_we), 32'(w));
      check("R12", "cap_size", 32'(cap_size), 32'(s));
      check("R12", "cap_data", cap_data, w ? d : 32'h0);
    end
    if (x_ctrl) begin
      if (s != 2'b00) flag_m = d[15];
      else if (!a[0]) flag_m = d[7];
    end
    check("R9", "map_en", 32'(map_en), 32'(flag_m));
  endtask

  task automatic probe_big(input logic [23:0] a, input logic exp_rom, input logic exp_ram);
    @(negedge clk);
    req = 1'b1; we = 1'b0; sz = 2'b10; addr = a; wdata = '0;
    #1;
    check("R4", "big rom/ram", 32'({b_rom, b_ram}), 32'({exp_rom, exp_ram}));
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; sz = 2'b10; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset outputs", 32'({map_en, unh, cap_we, cap_size}), 32'h0);
    check("R1", "reset cap_addr", 32'(cap_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release", 32'({map_en, unh}), 32'h0);
    check("R1", "cap_data", cap_data, 32'h0);

    // idle with an address that would hit RAM
    addr = 24'h000040; #1;
    check("R14", "idle selects", 32'({cs_rom, cs_ram, cs_map, cs_vram, cs_slot, mirror, own}), 32'h0);
    @(negedge clk); #1;
    check("R14", "idle pulse", 32'(unh), 32'h0);

    // overlay active: every block lands in ROM or upper zone
    for (int b = 0; b < 256; b++)
      access({8'(b), 16'(b * 311)}, 1'b0, 2'b10, 32'h0);
    access(24'h000010, 1'b0, 2'b01, 32'h0);

    // leave overlay with a word write
    access(24'hE43000, 1'b1, 2'b01, 32'h0000_8000);

    for (int b = 0; b < 256; b++)
      access({8'(b), 16'(b * 311)}, 1'b0, 2'(b % 3), 32'h0);
    for (int b = 0; b < 256; b++)
      access({8'(b), 16'(b * 173)}, 1'b1, 2'(b % 3), 32'(b * 32'h0101_0007));

    // boundaries and mirrors
    access(24'(RAM_B - 1), 1'b0, 2'b00, 32'h0);
    access(24'(RAM_B), 1'b0, 2'b00, 32'h0);
    access(24'h4007FF, 1'b0, 2'b00, 32'h0);
    access(24'h400800, 1'b1, 2'b00, 32'h5A);
    access(24'h427FFF, 1'b0, 2'b01, 32'h0);
    access(24'h428000, 1'b0, 2'b01, 32'h0);
    access(24'h3FFFFF, 1'b0, 2'b10, 32'h0);
    access(24'h450000, 1'b0, 2'b01, 32'h0);

    // status formats and ignored writes
    access(24'h410000, 1'b0, 2'b00, 32'h0);
    access(24'h410001, 1'b0, 2'b00, 32'h0);
    access(24'h430001, 1'b0, 2'b00, 32'h0);
    access(24'h440000, 1'b0, 2'b01, 32'h0);
    access(24'h440002, 1'b0, 2'b10, 32'h0);
    access(24'h430000, 1'b1, 2'b01, 32'hFFFF_FFFF);
    access(24'h430000, 1'b0, 2'b01, 32'h0);

    // slots
    access(24'hDC1234, 1'b1, 2'b01, 32'hBEEF);
    access(24'hC40002, 1'b0, 2'b10, 32'h0);

    // overlay control sequences
    access(24'hE43001, 1'b1, 2'b00, 32'h0000_0000);
    access(24'hE43000, 1'b0, 2'b10, 32'h0);
    access(24'hE43000, 1'b1, 2'b00, 32'h0000_0000);
    access(24'h000010, 1'b0, 2'b10, 32'h0);
    access(24'hF43FFE, 1'b1, 2'b00, 32'h0000_0080);
    access(24'hF43000, 1'b1, 2'b10, 32'h0000_0000);
    access(24'h000020, 1'b0, 2'b01, 32'h0);
    access(24'hE43000, 1'b1, 2'b10, 32'h0000_8000);
    access(24'h000020, 1'b0, 2'b01, 32'h0);

    // large RAM configuration: ROM wins, RAM hides zone A
    probe_big(24'h900000, 1'b1, 1'b0);
    probe_big(24'h500000, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule